// File: doc/BRIEF.md
# Double-Data-Rate Output Register Pair

This block is the output stage for a double-rate pin. The core logic prepares two bits per clock in its rising-edge domain: one meant for the high half of the clock period and one for the low half. The block stores each bit in its own register and selects between the two register outputs with the clock level. The result is a single output that changes on both clock edges.

The upper register runs on `clk_a`. The lower register runs on `clk_b`, which is normally the inverse of `clk_a` and so sits 180 degrees away from it. The two registers share one clock enable. They also share a set/reset control and a reverse control. The set/reset control forces a parameterised level, and the reverse control forces the opposite level. When both are asserted, each register goes to 0.

A second, optional pair drives the output-enable (three-state) bit with the same timing. That pair has its own enable and uses the same set/reset, reverse and reset lines. The block does not include input-side capture or the pad driver.

Top module: `ddr_out_stage`

## Requirements
- R1: On each rising edge of `clk_a` with `ce` high and `sr`, `rev` low, the upper register loads `d_rise`.
- R2: On each rising edge of `clk_b` with `ce` high and `sr`, `rev` low, the lower register loads `d_fall`.
- R3: `pad_q` equals the upper register while `clk_a` is 1, and equals the lower register while `clk_a` is 0.
- R4: With `ce` low and `sr`, `rev` low, both registers hold their values. `pad_q` then keeps alternating between the two held words.
- R5: `sr` high with `rev` low forces every bit of a register to `SR_LEVEL` (default 0) on that register's next clock edge.
- R6: `rev` high with `sr` low forces every bit to the inverse of `SR_LEVEL` (default 1) on that register's next clock edge.
- R7: `sr` and `rev` high together force every bit of every register to 0, whatever `SR_LEVEL` is.
- R8: `sr` and `rev` act whether or not the enables are high, and they take priority over loading data.
- R9: `rst_n` low is a synchronous, active-low reset. At each register's own next clock edge it sets that register to 0. It takes priority over `sr`, `rev` and the enables.
- R10: When `HAS_OE` is 1, `pad_oe` comes from a second pair. That pair loads `oe_rise` on `clk_a` and `oe_fall` on `clk_b`, uses `oe_ce` as its enable, and follows R3, R5 to R9 with `OE_SR_LEVEL` (default 0). When `HAS_OE` is 0, `pad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock for the upper registers; its level drives the output select |
| clk_b | input | 1 | Clock for the lower registers, normally the inverse of clk_a |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Enable shared by the data register pair |
| oe_ce | input | 1 | Enable shared by the output-enable register pair |
| sr | input | 1 | Set/reset control: forces the SR level |
| rev | input | 1 | Reverse control: forces the inverse of the SR level |
| d_rise | input | W | Data word shown while clk_a is high |
| d_fall | input | W | Data word shown while clk_a is low |
| oe_rise | input | 1 | Output-enable bit shown while clk_a is high |
| oe_fall | input | 1 | Output-enable bit shown while clk_a is low |
| pad_q | output | W | Double-rate data output |
| pad_oe | output | 1 | Double-rate output-enable |

## Verification
Several controls can act in the same cycle, and the key case is `sr` and `rev` both asserted while `ce` is high and fresh data sits at the inputs. The bench produces this case directly, and it also drives random cycles in which each control goes high on its own. The priority order reset, then conflict, then set/reset, then reverse, then load, then hold decides the expected value. The bench compares `pad_q` and `pad_oe` in the low half and the high half of every period.

// File: rtl/ddr_pkg.sv
// Package: shared types for the double-rate output stage.
// Assumes: nothing beyond IEEE 1800-2017.
package ddr_pkg;

    // Action a storage register takes at its next active edge.
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_LOAD  = 3'd1,
        ACT_LEVEL = 3'd2,
        ACT_INV   = 3'd3,
        ACT_ZERO  = 3'd4
    } reg_act_e;

endpackage

// File: rtl/ddr_ctl_decode.sv
// Module: ddr_ctl_decode
// Turns the shared enable, set/reset and reverse lines into one action
// code for a register pair. Conflict (both forcing lines) wins, then
// set/reset, then reverse, then the enable. Reset is applied in the
// registers themselves.
// Assumes: inputs are stable around both clocks' active edges.
module ddr_ctl_decode
    import ddr_pkg::*;
(
    input  logic     en,
    input  logic     sr,
    input  logic     rev,
    output reg_act_e act
);

    // Priority decode of the control lines.
    always_comb begin
        if (sr && rev)   act = ACT_ZERO;
        else if (sr)     act = ACT_LEVEL;
        else if (rev)    act = ACT_INV;
        else if (en)     act = ACT_LOAD;
        else             act = ACT_HOLD;
    end

endmodule

// File: rtl/ddr_store_reg.sv
// Module: ddr_store_reg
// One W-bit storage register on its own clock. A synchronous active-low
// reset clears it, and the decoded action code selects the next value.
// Assumes: act and d are settled at the active edge of clk.
module ddr_store_reg
    import ddr_pkg::*;
#(
    parameter int   W     = 4,
    parameter logic LEVEL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_act_e     act,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] LVL_WORD = {W{LEVEL}};
    localparam logic [W-1:0] INV_WORD = {W{~LEVEL}};

    // Capture, force or hold on the register's own edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (act)
                ACT_LOAD:  q <= d;
                ACT_LEVEL: q <= LVL_WORD;
                ACT_INV:   q <= INV_WORD;
                ACT_ZERO:  q <= '0;
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/ddr_edge_pair.sv
// Module: ddr_edge_pair
// Two storage registers, an upper one on clk_a and a lower one on clk_b,
// with a mux that shows the upper one while clk_a is high and the lower
// one while it is low. Both registers share one enable and the
// set/reset/reverse lines.
// Assumes: clk_b is clk_a inverted, so the lower register samples at the
// falling edge of clk_a.
module ddr_edge_pair
    import ddr_pkg::*;
#(
    parameter int   W     = 4,
    parameter logic LEVEL = 1'b0
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_n,
    input  logic         en,
    input  logic         sr,
    input  logic         rev,
    input  logic [W-1:0] d_hi,
    input  logic [W-1:0] d_lo,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] LVL_WORD = {W{LEVEL}};

    reg_act_e     act;
    logic [W-1:0] q_up;
    logic [W-1:0] q_lo;

    ddr_ctl_decode i_dec (
        .en  (en),
        .sr  (sr),
        .rev (rev),
        .act (act)
    );

    ddr_store_reg #(.W(W), .LEVEL(LEVEL)) i_up (
        .clk   (clk_a),
        .rst_n (rst_n),
        .act   (act),
        .d     (d_hi),
        .q     (q_up)
    );

    ddr_store_reg #(.W(W), .LEVEL(LEVEL)) i_lo (
        .clk   (clk_b),
        .rst_n (rst_n),
        .act   (act),
        .d     (d_lo),
        .q     (q_lo)
    );

    // Select the register that owns the current half period.
    always_comb begin
        q = clk_a ? q_up : q_lo;
    end

    // Conflict on the forcing lines clears the upper register.
    assert_conflict_zero_R7: assert property (@(posedge clk_a) disable iff (!rst_n)
        (sr && rev) |=> (q_up == '0));

    // Set/reset alone drives the level, whatever the enable is.
    assert_sr_level_R5: assert property (@(posedge clk_b) disable iff (!rst_n)
        (sr && !rev) |=> (q_lo == LVL_WORD));

    // Reverse alone drives the opposite level.
    assert_rev_inverse_R6: assert property (@(posedge clk_a) disable iff (!rst_n)
        (rev && !sr) |=> (q_up == ~LVL_WORD));

    // With nothing active, the lower register holds.
    assert_hold_R4: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!en && !sr && !rev) |=> $stable(q_lo));

    // With the enable alone, the upper register loads the presented word.
    assert_load_R1: assert property (@(posedge clk_a) disable iff (!rst_n)
        (en && !sr && !rev) |=> (q_up == $past(d_hi)));

endmodule

// File: rtl/ddr_out_stage.sv
// Module: ddr_out_stage
// Top of the double-rate output stage: a W-bit data pair and, when
// HAS_OE is set, a one-bit output-enable pair with its own enable.
// Both pairs share the clocks, the reset and the forcing lines.
// Assumes: clk_b is the inverse of clk_a; inputs come from the clk_a
// rising-edge domain and are settled before the next falling edge.
module ddr_out_stage #(
    parameter int   W           = 4,
    parameter bit   HAS_OE      = 1'b1,
    parameter logic SR_LEVEL    = 1'b0,
    parameter logic OE_SR_LEVEL = 1'b0
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         oe_ce,
    input  logic         sr,
    input  logic         rev,
    input  logic [W-1:0] d_rise,
    input  logic [W-1:0] d_fall,
    input  logic         oe_rise,
    input  logic         oe_fall,
    output logic [W-1:0] pad_q,
    output logic         pad_oe
);

    ddr_edge_pair #(.W(W), .LEVEL(SR_LEVEL)) i_data (
        .clk_a (clk_a),
        .clk_b (clk_b),
        .rst_n (rst_n),
        .en    (ce),
        .sr    (sr),
        .rev   (rev),
        .d_hi  (d_rise),
        .d_lo  (d_fall),
        .q     (pad_q)
    );

    // Output-enable pair, present only when requested.
    generate
        if (HAS_OE) begin : g_oe
            ddr_edge_pair #(.W(1), .LEVEL(OE_SR_LEVEL)) i_oe (
                .clk_a (clk_a),
                .clk_b (clk_b),
                .rst_n (rst_n),
                .en    (oe_ce),
                .sr    (sr),
                .rev   (rev),
                .d_hi  (oe_rise),
                .d_lo  (oe_fall),
                .q     (pad_oe)
            );
        end else begin : g_no_oe
            logic unused_oe;
            // Tie the enable output low; keep the unused pins referenced.
            always_comb begin
                unused_oe = oe_ce ^ oe_rise ^ oe_fall;
                pad_oe    = 1'b0;
            end
        end
    endgenerate

endmodule

// File: tb/test_ddr_out_stage.sv
`timescale 1ns/1ps
module test_ddr_out_stage;

    localparam int W = 4;

    logic         clk_a = 1'b0;
    logic         clk_b;
    logic         rst_n, ce, oe_ce, sr, rev, oe_rise, oe_fall;
    logic [W-1:0] d_rise, d_fall;
    logic [W-1:0] pad_q;
    logic         pad_oe;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [W-1:0] up_m, lo_m;
    logic         oeu_m, oel_m;

    always #2.5 clk_a = ~clk_a;
    assign clk_b = ~clk_a;

    ddr_out_stage #(.W(W)) i_ddr_out_stage (
        .clk_a (clk_a), .clk_b (clk_b), .rst_n (rst_n), .ce (ce),
        .oe_ce (oe_ce), .sr (sr), .rev (rev), .d_rise (d_rise),
        .d_fall (d_fall), .oe_rise (oe_rise), .oe_fall (oe_fall),
        .pad_q (pad_q), .pad_oe (pad_oe)
    );

    // Expected next value of a register from the requirement priorities (SR level 0).
    function automatic logic [W-1:0] nxt(logic [W-1:0] q, logic [W-1:0] d,
                                         logic en, logic s, logic r, logic rn);
        if (!rn)        return '0;          // R9
        if (s && r)     return '0;          // R7
        if (s)          return '0;          // R5
        if (r)          return '1;          // R6
        if (en)         return d;           // R1 / R2
        return q;                           // R4
    endfunction

    function automatic string tag_of(string load_tag, logic en, logic s, logic r, logic rn);
        if (!rn)    return "R9";
        if (s && r) return "R7";
        if (s)      return en ? "R5" : "R8";
        if (r)      return en ? "R6" : "R8";
        if (en)     return load_tag;
        return "R4";
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One period, entered at rising edge + 1 ns; checks the low half then the high half.
    task automatic cycle(string tg, logic rn, logic en, logic oen, logic s, logic r,
                         logic [W-1:0] dr, logic [W-1:0] df, logic or_, logic of_);
        rst_n = rn; ce = en; oe_ce = oen; sr = s; rev = r;
        d_rise = dr; d_fall = df; oe_rise = or_; oe_fall = of_;
        lo_m  = nxt(lo_m, df, en, s, r, rn);
        oel_m = nxt({W{oel_m}}, {W{of_}}, oen, s, r, rn) != 0;
        #2;
        check(tg == "" ? tag_of("R2", en, s, r, rn) : tg, pad_q, lo_m);
        check("R10", {{(W-1){1'b0}}, pad_oe}, {{(W-1){1'b0}}, oel_m});
        #3;
        up_m  = nxt(up_m, dr, en, s, r, rn);
        oeu_m = nxt({W{oeu_m}}, {W{or_}}, oen, s, r, rn) != 0;
        check(tg == "" ? tag_of("R1", en, s, r, rn) : tg, pad_q, up_m);
        check("R10", {{(W-1){1'b0}}, pad_oe}, {{(W-1){1'b0}}, oeu_m});
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        rst_n = 0; ce = 0; oe_ce = 0; sr = 0; rev = 0;
        d_rise = '0; d_fall = '0; oe_rise = 0; oe_fall = 0;
        up_m = '0; lo_m = '0; oeu_m = 0; oel_m = 0;
        @(posedge clk_a); #1;
        // R9: reset clears both registers, even with rev high
        cycle("R9", 0, 1, 1, 0, 1, 4'hF, 4'hF, 1, 1);
        cycle("R9", 0, 1, 1, 0, 0, 4'hA, 4'h5, 1, 1);
        // R3: distinct words per half period
        cycle("R3", 1, 1, 1, 0, 0, 4'hA, 4'h5, 1, 0);
        cycle("R3", 1, 1, 1, 0, 0, 4'h3, 4'hC, 0, 1);
        cycle("R3", 1, 1, 1, 0, 0, 4'h9, 4'h6, 1, 1);
        // R4: enable low holds and output keeps alternating
        cycle("R4", 1, 0, 0, 0, 0, 4'h0, 4'hF, 0, 0);
        cycle("R4", 1, 0, 0, 0, 0, 4'h7, 4'h1, 0, 0);
        // R6 then R5
        cycle("R6", 1, 1, 1, 0, 1, 4'h2, 4'h4, 0, 0);
        cycle("R5", 1, 1, 1, 1, 0, 4'hF, 4'hF, 1, 1);
        // R7: conflict with enable and fresh data in the same cycle
        cycle("R6", 1, 0, 0, 0, 1, 4'h0, 4'h0, 0, 0);
        cycle("R7", 1, 1, 1, 1, 1, 4'hF, 4'hF, 1, 1);
        // R8: forcing lines act with enables low
        cycle("R8", 1, 0, 0, 0, 1, 4'h0, 4'h0, 0, 0);
        cycle("R8", 1, 0, 0, 1, 0, 4'hF, 4'hF, 1, 1);
        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic rn, en, oen, s, r;
            rn  = ($urandom % 40) != 0;
            en  = ($urandom % 4) != 0;
            oen = ($urandom % 3) != 0;
            s   = ($urandom % 8) == 0;
            r   = ($urandom % 8) == 0;
            cycle("", rn, en, oen, s, r, W'($urandom), W'($urandom),
                  1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule